// File: doc/BRIEF.md
# Byte-Writable Memory Core with Single-Error Correction

This block is a synchronous, clocked model of a 16-bit-wide memory array. Every stored entry keeps both data bytes together with six check bits. The check bits form a single-error-correcting Hamming code. On every read, the block decodes the stored codeword, repairs any one flipped bit, and returns the repaired data. An error flag comes out in the same cycle as that data.

The control inputs follow the usual asynchronous-SRAM convention. The chip is selected by a pair of enables: one is active low and the other is active high. Each data byte has its own active-low enable. The write and output enables are active low. A write that covers only one byte cannot simply overwrite the stored codeword, because the check bits span the whole word. The block therefore performs a read, correct, merge and re-encode sequence, which costs one extra cycle. During that cycle it raises `busy`.

A test port XORs any bit pattern into a stored codeword. This lets a bench plant faults in data bits and in check bits. Output drive is not a tri-state. Instead, the block reports it as a per-byte enable next to the registered read data.

Top module: `ecc_sram_core`

## Requirements
- R1: An access is accepted only while `cs_a_n`=0 and `cs_b`=1. With any other chip-enable combination, writes leave memory unchanged and no read lane is driven.
- R2: `standby` is registered. One cycle after the inputs are sampled, it is 1 if the chip is deselected or if both `ub_n` and `lb_n` are 1. In the second case this holds whatever the chip enables are, and a write request is ignored.
- R3: A read (`we_n`=1, `oe_n`=0) accepted at clock edge N appears at edge N+1. `rd_drive` bit 1 is the upper byte (data 15..8, enabled by `ub_n`=0) and bit 0 is the lower byte (data 7..0, enabled by `lb_n`=0). A lane that is not driven reads as zero.
- R4: When selected with `we_n`=1 and `oe_n`=1, the block is active but output-disabled. No lane is driven and stored data is untouched.
- R5: A write with both byte enables low stores the whole word at the accepting edge and does not raise `busy`. A read in the next cycle returns the new word.
- R6: A write with exactly one byte enable low raises `busy` for one cycle. It then stores the new byte and keeps the other byte of the corrected stored word, re-encoded so that later reads are clean.
- R7: If a stored codeword has any single flipped bit, a read returns the original data with `err_fix`=1, in the same cycle as the data. The codeword layout is: bit 0 is overall parity, bits 1, 2, 4, 8 and 16 are Hamming checks, and the remaining bits hold data bits 0..15 in ascending order.
- R8: A read of a fault-free word returns `err_fix`=0.
- R9: `inj_en`=1 XORs `inj_mask` into the codeword stored at `inj_addr` and raises `busy` for one cycle. In the same cycle, injection takes precedence over, and cancels, any data access.
- R10: Requests presented while `busy`=1 are dropped.
- R11: After reset, `rd_data`=0, `rd_drive`=0, `err_fix`=0, `busy`=0 and `standby`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_a_n | input | 1 | Chip enable, active low |
| cs_b | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | ADDR_W | Word address |
| wr_data | input | 16 | Write data |
| inj_en | input | 1 | Fault injection strobe |
| inj_addr | input | ADDR_W | Word address for injection |
| inj_mask | input | 22 | Bits to flip in the stored codeword |
| rd_data | output | 16 | Corrected read data, zero in undriven lanes |
| rd_drive | output | 2 | Per-byte output drive enable |
| err_fix | output | 1 | A single-bit error was corrected in this read |
| busy | output | 1 | Internal read-modify-write cycle in progress |
| standby | output | 1 | Deselected or no byte enabled |

## Verification
Results arrive at different delays after the input edge:
- Read data, lane drive and the error flag appear two rising edges after the request is driven: the array read is registered first, then the decoded result.
- `busy` and `standby` appear after a single edge.

The bench drives each stimulus on a falling edge and then samples on a later falling edge: the first one for `busy` and `standby`, the second one for read results. Every sample therefore lands half a period after the edge that produced it. For partial writes and injections, the bench waits out the `busy` cycle before starting the next access. In the one scenario that deliberately drives a request into that cycle, it checks that the request had no effect.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DW    = 16;          // data bits per word
  localparam int PW    = 5;           // Hamming position checks
  localparam int CW    = DW + PW + 1; // plus overall parity at bit 0
  localparam int LANES = DW / 8;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_MERGE, OP_INJ} op_e;

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CW-1:0] hm_encode(input logic [DW-1:0] d);
    logic [CW-1:0] cw;
    int k;
    cw = '0;
    k  = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        cw[p] = d[k];
        k++;
      end
    end
    for (int j = 0; j < PW; j++) begin
      logic par;
      par = 1'b0;
      for (int p = 1; p < CW; p++)
        if (((p >> j) & 1) != 0) par = par ^ cw[p];
      cw[1 << j] = par;
    end
    cw[0] = ^cw[CW-1:1];
    return cw;
  endfunction

  function automatic logic [PW-1:0] hm_syndrome(input logic [CW-1:0] cw);
    logic [PW-1:0] s;
    s = '0;
    for (int j = 0; j < PW; j++)
      for (int p = 1; p < CW; p++)
        if (((p >> j) & 1) != 0) s[j] = s[j] ^ cw[p];
    return s;
  endfunction

  function automatic logic [DW-1:0] hm_data(input logic [CW-1:0] cw);
    logic [DW-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int p = 1; p < CW; p++) begin
      if (!is_pow2(p)) begin
        d[k] = cw[p];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/ecc_ram.sv
module ecc_ram #(
  parameter int ADDR_W = 10,
  parameter int WIDTH  = 22
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_sram_pkg::*;
(
  input  logic [DW-1:0] d_i,
  output logic [CW-1:0] cw_o
);
  assign cw_o = hm_encode(d_i);
endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_sram_pkg::*;
(
  input  logic [CW-1:0] cw_i,
  output logic [DW-1:0] d_o,
  output logic          err_o
);
  logic [PW-1:0] syn;
  logic          par_bad;
  logic [CW-1:0] fixed;

  assign syn     = hm_syndrome(cw_i);
  assign par_bad = ^cw_i;

  // a nonzero syndrome names the flipped position; zero syndrome with
  // bad overall parity means bit 0 itself flipped (no data impact)
  always_comb begin
    fixed = cw_i;
    if (syn != '0 && int'(syn) < CW) fixed[syn] = ~cw_i[syn];
  end

  assign d_o   = hm_data(fixed);
  assign err_o = (syn != '0) | par_bad;
endmodule

// File: rtl/ecc_sram_core.sv
module ecc_sram_core
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_a_n,
  input  logic              cs_b,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [CW-1:0]     inj_mask,
  output logic [DW-1:0]     rd_data,
  output logic [LANES-1:0]  rd_drive,
  output logic              err_fix,
  output logic              busy,
  output logic              standby
);
  // ---- request decode (R1, R2, R9, R10) ----
  logic             sel;
  logic [LANES-1:0] lane_en;
  logic             any_lane, open_slot;
  logic             take_inj, rd_req, wr_req, full_wr, part_wr;

  assign sel       = ~cs_a_n & cs_b;
  assign lane_en   = {~ub_n, ~lb_n};
  assign any_lane  = |lane_en;
  assign open_slot = sel & any_lane & ~busy & ~inj_en;
  assign take_inj  = inj_en & ~busy;
  assign rd_req    = open_slot & we_n & ~oe_n;
  assign wr_req    = open_slot & ~we_n;
  assign full_wr   = wr_req & (&lane_en);
  assign part_wr   = wr_req & ~(&lane_en);

  // ---- stage registers ----
  op_e              op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] lanes_q;
  logic [CW-1:0]    mask_q;

  assign busy = (op_q == OP_MERGE) || (op_q == OP_INJ);

  // ---- array and codec ----
  logic [CW-1:0]     ram_q, ram_wdata, enc_cw;
  logic [DW-1:0]     dec_data, merged, enc_in;
  logic              dec_err;
  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;

  ecc_decoder u_dec (
    .cw_i (ram_q),
    .d_o  (dec_data),
    .err_o(dec_err)
  );

  // R6: new byte where enabled, corrected old byte elsewhere
  for (genvar b = 0; b < LANES; b++) begin : g_merge
    assign merged[b*8 +: 8] = lanes_q[b] ? wdata_q[b*8 +: 8] : dec_data[b*8 +: 8];
  end

  assign enc_in = (op_q == OP_MERGE) ? merged : wr_data;

  ecc_encoder u_enc (
    .d_i (enc_in),
    .cw_o(enc_cw)
  );

  assign ram_re    = rd_req | part_wr | take_inj;
  assign ram_raddr = take_inj ? inj_addr : addr;
  assign ram_we    = full_wr | busy;
  assign ram_waddr = busy ? addr_q : addr;
  assign ram_wdata = (op_q == OP_INJ) ? (ram_q ^ mask_q) : enc_cw;

  ecc_ram #(
    .ADDR_W(ADDR_W),
    .WIDTH (CW)
  ) u_ram (
    .clk  (clk),
    .we   (ram_we),
    .waddr(ram_waddr),
    .wdata(ram_wdata),
    .re   (ram_re),
    .raddr(ram_raddr),
    .rdata(ram_q)
  );

  // ---- control and capture ----
  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= OP_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
      lanes_q <= '0;
      mask_q  <= '0;
      standby <= 1'b1;
    end else begin
      standby <= ~(sel & any_lane);
      if (take_inj)     op_q <= OP_INJ;
      else if (part_wr) op_q <= OP_MERGE;
      else if (rd_req)  op_q <= OP_READ;
      else              op_q <= OP_NONE;
      if (take_inj) begin
        addr_q <= inj_addr;
        mask_q <= inj_mask;
      end else if (open_slot) begin
        addr_q  <= addr;
        wdata_q <= wr_data;
        lanes_q <= lane_en;
      end
    end
  end

  // ---- registered read outputs (R3, R7, R8) ----
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_drive <= '0;
      err_fix  <= 1'b0;
    end else if (op_q == OP_READ) begin
      rd_drive <= lanes_q;
      err_fix  <= dec_err;
    end else begin
      rd_drive <= '0;
      err_fix  <= 1'b0;
    end
  end

  for (genvar b = 0; b < LANES; b++) begin : g_rdlane
    always_ff @(posedge clk) begin
      if (rst)
        rd_data[b*8 +: 8] <= '0;
      else if (op_q == OP_READ && lanes_q[b])
        rd_data[b*8 +: 8] <= dec_data[b*8 +: 8];
      else
        rd_data[b*8 +: 8] <= '0;
    end
  end
endmodule

// File: rtl/ecc_sram_core_chk.sv
module ecc_sram_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_a_n,
  input logic        cs_b,
  input logic        we_n,
  input logic        oe_n,
  input logic        ub_n,
  input logic        lb_n,
  input logic        inj_en,
  input logic [15:0] rd_data,
  input logic [1:0]  rd_drive,
  input logic        err_fix,
  input logic        busy,
  input logic        standby
);
  logic sel_c;
  assign sel_c = ~cs_a_n & cs_b;

  p_full_nobusy_r5: assert property (@(posedge clk) disable iff (rst)
    (sel_c && !we_n && !ub_n && !lb_n && !busy && !inj_en) |=> !busy);

  p_merge_busy_r6: assert property (@(posedge clk) disable iff (rst)
    (sel_c && !we_n && (ub_n ^ lb_n) && !busy && !inj_en) |=> busy);

  p_inj_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (inj_en && !busy) |=> busy);

  p_busy_single_r10: assert property (@(posedge clk) disable iff (rst)
    busy |=> !busy);

  p_standby_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    standby |=> (rd_drive == 2'b00));

  p_read_lanes_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_c && we_n && !oe_n && !(ub_n && lb_n) && !busy && !inj_en)
      |=> ##1 (rd_drive == $past({~ub_n, ~lb_n}, 2)));

  p_lo_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_drive[0] |-> (rd_data[7:0] == 8'h00));

  p_hi_zero_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_drive[1] |-> (rd_data[15:8] == 8'h00));

  p_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    (sel_c && we_n && oe_n) |=> ##1 (rd_drive == 2'b00));

  p_deselect_r1: assert property (@(posedge clk) disable iff (rst)
    !sel_c |=> standby);

  p_err_with_data_r7: assert property (@(posedge clk) disable iff (rst)
    err_fix |-> (rd_drive != 2'b00));
endmodule

bind ecc_sram_core ecc_sram_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs_a_n  (cs_a_n),
  .cs_b    (cs_b),
  .we_n    (we_n),
  .oe_n    (oe_n),
  .ub_n    (ub_n),
  .lb_n    (lb_n),
  .inj_en  (inj_en),
  .rd_data (rd_data),
  .rd_drive(rd_drive),
  .err_fix (err_fix),
  .busy    (busy),
  .standby (standby)
);

// File: tb/tb_ecc_sram_core.sv
`timescale 1ns/1ps
module tb_ecc_sram_core;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_a_n, cs_b, we_n, oe_n, ub_n, lb_n, inj_en;
  logic [AW-1:0] addr, inj_addr;
  logic [15:0]   wr_data;
  logic [21:0]   inj_mask;
  logic [15:0]   rd_data;
  logic [1:0]    rd_drive;
  logic          err_fix, busy, standby;

  int checks = 0;
  int errors = 0;
  logic [15:0] shadow [0:(1<<AW)-1];

  always #2 clk = ~clk;

  ecc_sram_core #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b(cs_b), .we_n(we_n),
    .oe_n(oe_n), .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wr_data(wr_data),
    .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask),
    .rd_data(rd_data), .rd_drive(rd_drive), .err_fix(err_fix),
    .busy(busy), .standby(standby)
  );

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle();
    cs_a_n = 1'b1; cs_b = 1'b0; we_n = 1'b1; oe_n = 1'b1;
    ub_n = 1'b1; lb_n = 1'b1; inj_en = 1'b0;
    addr = '0; wr_data = '0; inj_addr = '0; inj_mask = '0;
  endtask

  task automatic drive(input logic c1n, c2, wen, oen, ubn, lbn,
                       input logic [AW-1:0] a, input logic [15:0] d);
    cs_a_n = c1n; cs_b = c2; we_n = wen; oe_n = oen;
    ub_n = ubn; lb_n = lbn; addr = a; wr_data = d;
  endtask

  // write with full control; returns busy and standby one edge later
  task automatic raw_write(input logic c1n, c2, ubn, lbn,
                           input logic [AW-1:0] a, input logic [15:0] d,
                           output logic b, output logic s);
    @(negedge clk); drive(c1n, c2, 1'b0, 1'b1, ubn, lbn, a, d);
    @(negedge clk); idle(); b = busy; s = standby;
    if (b) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [15:0] d,
                          input logic ubn, lbn, output logic b);
    logic s;
    raw_write(1'b0, 1'b1, ubn, lbn, a, d, b, s);
    if (!ubn) shadow[a][15:8] = d[15:8];
    if (!lbn) shadow[a][7:0]  = d[7:0];
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic ubn, lbn, oen,
                         output logic [15:0] d, output logic [1:0] dr,
                         output logic e, output logic s);
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, oen, ubn, lbn, a, 16'h0);
    @(negedge clk); idle(); s = standby;
    @(negedge clk); d = rd_data; dr = rd_drive; e = err_fix;
  endtask

  task automatic do_inject(input logic [AW-1:0] a, input logic [21:0] m,
                           output logic b);
    @(negedge clk); inj_en = 1'b1; inj_addr = a; inj_mask = m;
    @(negedge clk); idle(); b = busy;
    @(negedge clk);
  endtask

  task automatic read_expect(input logic [AW-1:0] a, input logic [15:0] exp,
                             input logic exp_err, input string tag);
    logic [15:0] d; logic [1:0] dr; logic e, s;
    do_read(a, 1'b0, 1'b0, 1'b0, d, dr, e, s);
    check(d == exp, {tag, " data"}, 32'(d), 32'(exp));
    check(dr == 2'b11, {tag, " drive"}, 32'(dr), 32'h3);
    check(e == exp_err, {tag, " err_fix"}, 32'(e), 32'(exp_err));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check(rd_drive == 2'b00, "R11 rd_drive", 32'(rd_drive), 0);
    check(rd_data == 16'h0, "R11 rd_data", 32'(rd_data), 0);
    check(err_fix == 1'b0, "R11 err_fix", 32'(err_fix), 0);
    check(busy == 1'b0, "R11 busy", 32'(busy), 0);
    check(standby == 1'b1, "R11 standby", 32'(standby), 1);
  endtask

  task automatic t_full_write();
    logic b;
    do_write(10'h005, 16'hA5C3, 1'b0, 1'b0, b);
    check(b == 1'b0, "R5 no busy on full write", 32'(b), 0);
    do_write(10'h3FF, 16'h1234, 1'b0, 1'b0, b);
    do_write(10'h000, 16'hFFFF, 1'b0, 1'b0, b);
    // immediate read-back the cycle after the write
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'h077, 16'h0F0F);
    shadow[10'h077] = 16'h0F0F;
    @(negedge clk); drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 10'h077, 16'h0);
    @(negedge clk); idle();
    @(negedge clk);
    check(rd_data == 16'h0F0F, "R5 back-to-back read", 32'(rd_data), 32'h0F0F);
    read_expect(10'h005, 16'hA5C3, 1'b0, "R8 clean read a");
    read_expect(10'h3FF, 16'h1234, 1'b0, "R8 clean read b");
    read_expect(10'h000, 16'hFFFF, 1'b0, "R5 clean read c");
  endtask

  task automatic t_byte_reads();
    logic [15:0] d; logic [1:0] dr; logic e, s;
    do_read(10'h005, 1'b0, 1'b1, 1'b0, d, dr, e, s);
    check(dr == 2'b10, "R3 upper lane drive", 32'(dr), 32'h2);
    check(d == 16'hA500, "R3 upper lane data", 32'(d), 32'hA500);
    do_read(10'h005, 1'b1, 1'b0, 1'b0, d, dr, e, s);
    check(dr == 2'b01, "R3 lower lane drive", 32'(dr), 32'h1);
    check(d == 16'h00C3, "R3 lower lane data", 32'(d), 32'h00C3);
  endtask

  task automatic t_partial_write();
    logic b;
    do_write(10'h005, 16'h7E00, 1'b0, 1'b1, b);
    check(b == 1'b1, "R6 busy on upper write", 32'(b), 1);
    read_expect(10'h005, 16'h7EC3, 1'b0, "R6 upper merge");
    do_write(10'h3FF, 16'h0099, 1'b1, 1'b0, b);
    check(b == 1'b1, "R6 busy on lower write", 32'(b), 1);
    read_expect(10'h3FF, 16'h1299, 1'b0, "R6 lower merge");
  endtask

  task automatic t_output_disabled();
    logic [15:0] d; logic [1:0] dr; logic e, s;
    do_read(10'h005, 1'b0, 1'b0, 1'b1, d, dr, e, s);
    check(dr == 2'b00, "R4 no drive", 32'(dr), 0);
    check(d == 16'h0, "R4 data zero", 32'(d), 0);
    check(s == 1'b0, "R4 active not standby", 32'(s), 0);
    read_expect(10'h005, shadow[10'h005], 1'b0, "R4 contents kept");
  endtask

  task automatic t_deselect();
    logic b, s;
    raw_write(1'b1, 1'b1, 1'b0, 1'b0, 10'h005, 16'hDEAD, b, s);
    check(s == 1'b1, "R1 standby cs_a_n high", 32'(s), 1);
    raw_write(1'b0, 1'b0, 1'b0, 1'b0, 10'h005, 16'hBEEF, b, s);
    check(s == 1'b1, "R1 standby cs_b low", 32'(s), 1);
    read_expect(10'h005, shadow[10'h005], 1'b0, "R1 deselected write ignored");
  endtask

  task automatic t_byte_standby();
    logic b, s;
    raw_write(1'b0, 1'b1, 1'b1, 1'b1, 10'h3FF, 16'h5555, b, s);
    check(s == 1'b1, "R2 standby with no byte", 32'(s), 1);
    check(b == 1'b0, "R2 no busy", 32'(b), 0);
    read_expect(10'h3FF, shadow[10'h3FF], 1'b0, "R2 write ignored");
  endtask

  task automatic t_correct_all();
    logic b;
    for (int k = 0; k < 22; k++) begin
      logic [15:0] pat;
      pat = 16'h3C5A ^ 16'(k * 16'h0911);
      do_write(10'h020, pat, 1'b0, 1'b0, b);
      do_inject(10'h020, 22'(1) << k, b);
      check(b == 1'b1, $sformatf("R9 busy on inject bit %0d", k), 32'(b), 1);
      read_expect(10'h020, pat, 1'b1, $sformatf("R7 fix bit %0d", k));
    end
  endtask

  task automatic t_rmw_corrects();
    logic b;
    do_write(10'h030, 16'h8421, 1'b0, 1'b0, b);
    do_inject(10'h030, 22'h000040, b);     // data lane, position 6
    do_write(10'h030, 16'hEE00, 1'b0, 1'b1, b);
    read_expect(10'h030, 16'hEE21, 1'b0, "R6 merge repairs and re-encodes");
  endtask

  task automatic t_busy_drop();
    logic b;
    do_write(10'h040, 16'h1111, 1'b0, 1'b0, b);
    @(negedge clk); drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 10'h040, 16'h0022);
    @(negedge clk);
    check(busy == 1'b1, "R10 busy during merge", 32'(busy), 1);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'h040, 16'hDEAD);
    @(negedge clk); idle();
    check(busy == 1'b0, "R10 busy one cycle", 32'(busy), 0);
    shadow[10'h040] = 16'h1122;
    read_expect(10'h040, 16'h1122, 1'b0, "R10 request in busy dropped");
  endtask

  task automatic t_inj_priority();
    logic b;
    do_write(10'h050, 16'h0F0F, 1'b0, 1'b0, b);
    do_write(10'h051, 16'h6789, 1'b0, 1'b0, b);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 10'h050, 16'hBEEF);
    inj_en = 1'b1; inj_addr = 10'h051; inj_mask = 22'h000400;
    @(negedge clk); idle();
    check(busy == 1'b1, "R9 busy on inject", 32'(busy), 1);
    @(negedge clk);
    read_expect(10'h050, 16'h0F0F, 1'b0, "R9 access cancelled by inject");
    read_expect(10'h051, 16'h6789, 1'b1, "R9 injected word corrected");
  endtask

  initial begin
    idle();
    repeat (4) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_full_write();
    t_byte_reads();
    t_partial_write();
    t_output_disabled();
    t_deselect();
    t_byte_standby();
    t_correct_all();
    t_rmw_corrects();
    t_busy_drop();
    t_inj_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule